// File: doc/BRIEF.md
# HDLC Receive Deframer

This block takes a received HDLC bit stream one byte at a time. It finds the frames in that stream, strips the transparency bits, and checks each frame's length and frame check sequence. The caller presents one line byte per `in_valid` strobe. The eight bits of that byte are processed in the same cycle, least-significant bit first, which is the order they arrived on the line.

Inside a frame, the de-stuffed bits are packed into bytes and written to a frame store. A flag ends the current frame, and the same flag opens the next one. A closed frame is either accepted or silently dropped. An accepted frame is replayed on a ready/valid byte stream. The two check bytes are left off the replay, and the first and last data bytes are marked.

The frame store holds one frame. The store is not written while a frame is being replayed, so a frame that arrives during a replay is lost.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `out_valid` is low.
- R2: A frame is a flag (0x7E), then data bytes, then two check bytes, then a flag. Line bits are taken LSB first within each `in_byte`. For an accepted frame, `out_valid` rises in the cycle after the strobe that carries the closing flag. The data bytes come out in order, one per cycle while `out_ready` is high, without the check bytes. `out_first` marks the first byte and `out_last` marks the last. `out_valid` falls after the last byte is taken.
- R3: A 0 bit that follows five consecutive 1 bits inside a frame is removed before bytes are assembled. This means data bytes such as 0xFF, 0x7E, 0xF8 and 0x1F come out unchanged.
- R4: The check runs the reflected CRC-16 (polynomial 0x8408, preset 0xFFFF) over every received byte, check bytes included. A frame whose final value is not 0xF0B8 is discarded and produces no output.
- R5: A frame of fewer than 4 bytes, check bytes included, is discarded. A frame of exactly 4 bytes with a good check is released as 2 data bytes.
- R6: Seven or more consecutive 1 bits abort the current frame, which is discarded. Bits are then ignored until the next flag, and that flag opens a new frame normally.
- R7: One flag can close a frame and open the next one. Extra flags between frames are idle fill, and both frames are released.
- R8: A frame longer than DEPTH bytes, check bytes included, is discarded, and reception resumes at the next flag. A frame of exactly DEPTH bytes is accepted.
- R9: While a frame is being released, `out_data`, `out_first` and `out_last` hold steady whenever `out_valid` is high and `out_ready` is low. A frame that completes a byte during a release is discarded, and the frame being released is left intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: `in_byte` carries eight new line bits |
| in_byte | input | 8 | Line bits, earliest bit in bit 0 |
| out_ready | input | 1 | Consumer accepts the current output byte |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Released data byte |
| out_first | output | 1 | Current byte is the first of the frame |
| out_last | output | 1 | Current byte is the last of the frame |

## Verification
A frame's release is due in the cycle after the strobe that carries its closing flag. Each further byte follows one cycle after the previous byte is taken. The bench drives inputs just after a rising edge and compares every transferred byte at the falling edge against a queue of expected bytes. Strobes are spaced 16 cycles apart, so a release of up to six bytes always finishes before the next frame's first byte is complete. After each case the bench waits a fixed settling window longer than any release, then checks that nothing expected is still outstanding. Any transfer that has no matching expected byte is counted as a failure.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE  = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_REF = 16'h8408;
  localparam int          MIN_BYTES    = 4;
  localparam int          CHECK_BYTES  = 2;

  // one line bit into the reflected CRC register
  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_REF : 16'h0000);
  endfunction

  // a whole assembled byte, bit 0 first
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = crc_bit(r, d[i]);
    return r;
  endfunction

endpackage

// File: rtl/hdlc_rx_linescan.sv
module hdlc_rx_linescan
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 400,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          wr_block,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          close_evt,
  output logic          close_good,
  output logic [CW-1:0] close_len
);

  logic [2:0]    ones_q, n_ones;
  logic          inf_q, n_inf;
  logic [7:0]    sh_q, n_sh;
  logic [2:0]    bc_q, n_bc;
  logic [CW-1:0] cnt_q, n_cnt;
  logic [15:0]   crc_q, n_crc;
  logic          do_emit, ebit;

  always_comb begin
    n_ones = ones_q; n_inf = inf_q; n_sh = sh_q; n_bc = bc_q;
    n_cnt = cnt_q; n_crc = crc_q;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    close_evt = 1'b0; close_good = 1'b0; close_len = '0;
    do_emit = 1'b0; ebit = 1'b0;
    if (in_valid) begin
      for (int j = 0; j < 8; j++) begin
        do_emit = 1'b0;
        ebit    = in_byte[j];
        if (in_byte[j]) begin
          if (n_ones == 3'd6) begin
            n_ones = 3'd7;          // abort: back to hunt
            n_inf  = 1'b0;
          end else if (n_ones != 3'd7) begin
            n_ones  = n_ones + 3'd1;
            do_emit = n_inf;
          end
        end else begin
          if (n_ones == 3'd6) begin
            if (n_inf) begin
              close_evt  = 1'b1;
              close_len  = n_cnt;
              close_good = (n_cnt >= CW'(MIN_BYTES)) && (n_crc == CRC_RESIDUE);
            end
            n_inf = 1'b1;
            n_cnt = '0;
            n_crc = CRC_PRESET;
            n_bc  = 3'd0;
          end else if (n_ones != 3'd5 && n_ones != 3'd7) begin
            do_emit = n_inf;
          end
          n_ones = 3'd0;
        end
        if (do_emit) begin
          n_sh = {ebit, n_sh[7:1]};
          if (n_bc == 3'd7) begin
            n_bc = 3'd0;
            if (n_cnt == DEPTH[CW-1:0] || wr_block) begin
              n_inf = 1'b0;         // overflow or store busy: drop frame
            end else begin
              wr_en   = 1'b1;
              wr_addr = n_cnt[AW-1:0];
              wr_data = n_sh;
              n_crc   = crc_byte(n_crc, n_sh);
              n_cnt   = n_cnt + CW'(1);
            end
          end else begin
            n_bc = n_bc + 3'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= 3'd0; inf_q <= 1'b0; sh_q <= '0; bc_q <= 3'd0;
      cnt_q <= '0; crc_q <= CRC_PRESET;
    end else begin
      ones_q <= n_ones; inf_q <= n_inf; sh_q <= n_sh; bc_q <= n_bc;
      cnt_q <= n_cnt; crc_q <= n_crc;
    end
  end

endmodule

// File: rtl/hdlc_rx_release.sv
module hdlc_rx_release
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 400,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          accept,
  input  logic [CW-1:0] accept_len,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_first,
  output logic          out_last
);

  logic [7:0]    store [DEPTH];
  logic          busy_q;
  logic [CW-1:0] rd_q, len_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; rd_q <= '0; len_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      rd_q   <= '0;
      len_q  <= accept_len - CW'(CHECK_BYTES);
    end else if (busy_q && out_ready) begin
      if (out_last) busy_q <= 1'b0;
      else          rd_q   <= rd_q + CW'(1);
    end
  end

  assign out_valid = busy_q;
  assign out_data  = store[rd_q[AW-1:0]];
  assign out_first = (rd_q == '0);
  assign out_last  = (rd_q == len_q - CW'(1));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int DEPTH = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_first,
  output logic       out_last
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          close_evt, close_good;
  logic [CW-1:0] close_len;
  logic          frame_accept;

  hdlc_rx_linescan #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_scan (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .wr_block(out_valid), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .close_evt(close_evt), .close_good(close_good), .close_len(close_len)
  );

  assign frame_accept = close_evt && close_good && !out_valid;

  hdlc_rx_release #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_rel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .accept(frame_accept), .accept_len(close_len), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_last(out_last)
  );

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_first,
  input logic       out_last,
  input logic       wr_en,
  input logic       frame_accept
);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r2_release_next: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |=> out_valid && out_first);

  a_r2_start_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_first);

  a_r2_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                && $stable(out_first) && $stable(out_last));

  a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !wr_en);

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_first(out_first), .out_last(out_last),
  .wr_en(wr_en), .frame_accept(frame_accept)
);

// File: tb/test_hdlc_rx_deframer.sv
module test_hdlc_rx_deframer;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH_T    = 8;
  localparam int GAP        = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_ready = 1'b1;
  logic       out_valid, out_first, out_last;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  bit         line_q[$];
  logic [7:0] fr_q[$];
  logic [7:0] exp_data[$];
  bit         exp_first[$];
  bit         exp_last[$];
  int         tx_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_deframer #(.DEPTH(DEPTH_T)) i_hdlc_rx_deframer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // CRC restated byte-wise: xor the byte in, then eight shifts
  function automatic logic [15:0] fcs_of();
    logic [15:0] c = 16'hFFFF;
    foreach (fr_q[k]) begin
      c ^= {8'h00, fr_q[k]};
      repeat (8) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic put_flag();
    for (int i = 0; i < 8; i++) line_q.push_back(i != 0 && i != 7);
    tx_run = 0;
  endtask

  task automatic put_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) line_q.push_back(b[i]);
  endtask

  task automatic put_stuffed(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      line_q.push_back(b[i]);
      tx_run = b[i] ? tx_run + 1 : 0;
      if (tx_run == 5) begin line_q.push_back(1'b0); tx_run = 0; end
    end
  endtask

  // body + FCS + closing flag; corrupt flips a data bit after the FCS is fixed
  task automatic put_frame(input bit corrupt);
    logic [15:0] f;
    f = fcs_of();
    foreach (fr_q[k]) put_stuffed((k == 0 && corrupt) ? fr_q[k] ^ 8'h01 : fr_q[k]);
    put_stuffed(f[7:0]);
    put_stuffed(f[15:8]);
    put_flag();
  endtask

  task automatic expect_frame();
    foreach (fr_q[k]) begin
      exp_data.push_back(fr_q[k]);
      exp_first.push_back(k == 0);
      exp_last.push_back(k == fr_q.size() - 1);
    end
  endtask

  task automatic send_line();
    logic [7:0] b;
    while (line_q.size() % 8 != 0) line_q.push_back(1'b0);
    while (line_q.size() > 0) begin
      for (int i = 0; i < 8; i++) b[i] = line_q.pop_front();
      @(posedge clk); #1;
      in_valid = 1'b1; in_byte = b;
      @(posedge clk); #1;
      in_valid = 1'b0;
      repeat (GAP - 1) @(posedge clk);
    end
  endtask

  task automatic settle(input string req);
    repeat (60) @(posedge clk);
    #1;
    check(exp_data.size() == 0, req, "expected bytes still pending", exp_data.size(), 0);
  endtask

  // output monitor at the falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_data.size() == 0) begin
        check(1'b0, cur_req, "unexpected output byte", out_data, 0);
      end else begin
        logic [7:0] ed;
        bit ef, el;
        ed = exp_data.pop_front(); ef = exp_first.pop_front(); el = exp_last.pop_front();
        check(out_data == ed, cur_req, "data byte", out_data, ed);
        check(out_first == ef && out_last == el, cur_req, "first/last marks",
              {out_first, out_last}, {ef, el});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // R2 and R3: sweep data lengths and patterns (with stuffing-heavy bytes)
    cur_req = "R2";
    for (int len = 2; len <= DEPTH_T - 2; len++) begin
      for (int p = 0; p < 4; p++) begin
        cur_req = (p == 1 || p == 2) ? "R3" : "R2";
        fr_q.delete();
        for (int k = 0; k < len; k++) begin
          case (p)
            0: fr_q.push_back(8'((k * 17 + len) & 255));
            1: fr_q.push_back(8'hFF);
            2: fr_q.push_back((k % 2) ? 8'h7E : 8'hF8);
            default: fr_q.push_back(8'((k * 73 + len * 29 + 31) & 255));
          endcase
        end
        put_flag(); put_frame(1'b0); expect_frame(); send_line();
        settle(cur_req);
      end
    end

    // R4: check bytes do not match
    cur_req = "R4";
    fr_q = '{8'h12, 8'h34, 8'h56};
    put_flag(); put_frame(1'b1); send_line();
    settle("R4");

    // R5: three bytes total dropped, four bytes total accepted
    cur_req = "R5";
    fr_q = '{8'hA5};
    put_flag(); put_frame(1'b0); send_line();
    settle("R5");
    fr_q = '{8'h3C, 8'hC3};
    put_flag(); put_frame(1'b0); expect_frame(); send_line();
    settle("R5");

    // R6: abort mid-frame, junk while hunting, then a good frame
    cur_req = "R6";
    put_flag(); put_stuffed(8'h55); put_stuffed(8'h66); put_raw(8'hFF);
    put_raw(8'h12); put_raw(8'h34);
    fr_q = '{8'h9A, 8'hBC, 8'hDE};
    put_flag(); put_frame(1'b0); expect_frame(); send_line();
    settle("R6");

    // R7: shared flag between frames, then idle flags, then a third frame
    cur_req = "R7";
    put_flag();
    fr_q = '{8'h01, 8'h02, 8'h03}; put_frame(1'b0); expect_frame();
    fr_q = '{8'hF0, 8'h0F};        put_frame(1'b0); expect_frame();
    put_flag(); put_flag(); put_flag();
    fr_q = '{8'h7E, 8'h7E, 8'h7E}; put_frame(1'b0); expect_frame();
    send_line();
    settle("R7");

    // R8: one byte over the store depth dropped, following frame received
    cur_req = "R8";
    fr_q.delete();
    for (int k = 0; k < DEPTH_T - 1; k++) fr_q.push_back(8'(k + 64));
    put_flag(); put_frame(1'b0);
    fr_q.delete();
    for (int k = 0; k < DEPTH_T - 2; k++) fr_q.push_back(8'(k + 200));
    put_frame(1'b0); expect_frame(); send_line();
    settle("R8");

    // R9: hold output back; frame arriving during the release is lost
    cur_req = "R9";
    out_ready = 1'b0;
    put_flag();
    fr_q = '{8'h11, 8'h22, 8'h33}; put_frame(1'b0); expect_frame();
    fr_q = '{8'h44, 8'h55, 8'h66}; put_frame(1'b0);
    send_line();
    @(negedge clk);
    check(out_valid == 1'b1, "R9", "out_valid held", out_valid, 1);
    check(out_data == 8'h11, "R9", "held byte", out_data, 8'h11);
    check(out_first == 1'b1, "R9", "held first mark", out_first, 1);
    @(posedge clk); #1 out_ready = 1'b1;
    settle("R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule